// File: doc/BRIEF.md
# Packet Buffer Pointer and Data Port

This block is the host's access path into a packet buffer memory. The host loads a pointer with an 11-bit offset, a direction bit, an area-select bit and an auto-increment enable. After that it moves bytes or 16-bit words through a single data port. The buffer address is formed by placing a packet number above the offset, so each packet owns a 2 KB page. The packet number is taken from the receive queue head when the area-select bit is set, and from a packet number register input when it is clear.

Reads are served from a one-word prefetch register. Loading the pointer in read mode fetches the addressed word at once. Each host read hands over the prefetched data and then fetches the next location. Writes go into a four-entry queue that drains into memory whenever the memory grants it. A new pointer load is held off until that queue is empty.

The pointer value read back is the offset of the location the host last touched, not the offset being prefetched. Interrupt code can therefore save and restore it without disturbing a transfer in progress.

Top module: `pktbuf_ptr_port`

## Requirements
- R1: After reset, ptr_offset is 0, ptr_read is 0 (write mode), data_ready is 0 and wr_pending is 0.
- R2: A pointer load accepted with ld_read=1 drives mem_re in the next cycle. data_ready is high two cycles after the acceptance edge. dp_rdata for a word read is {byte at address+1, byte at address}, where the address is {packet number, offset}.
- R3: When ptr_autoinc=1, each accepted data access advances the internal offset by 1 for a byte access (dp_word=0) and by 2 for a word access (dp_word=1). When ptr_autoinc=0 the offset does not change.
- R4: When ptr_rx=1 the packet number in the upper address bits is rxq_head. When ptr_rx=0 it is pnum_reg.
- R5: When ptr_read=1, data accesses are reads. When ptr_read=0 they are writes that reach memory through mem_we, mem_addr, mem_word and mem_wdata. Byte writes carry the data in mem_wdata[7:0]. mem_re and mem_we are never high together.
- R6: ptr_offset equals the loaded offset after a load. After each accepted access it equals the offset of that access, even though the prefetch has already moved past it.
- R7: A read request while data_ready=0 is not acknowledged. After an accepted read, the next read is stalled for exactly two cycles.
- R8: The write queue holds 4 entries. While it is full a write request is not acknowledged. wr_pending is high whenever an entry has not yet reached memory (a write is taken by memory when mem_we and mem_wgnt are both high).
- R9: ptr_ack stays low while wr_pending=1. The held load is accepted in the first cycle after the last queued write is taken by memory.
- R10: The offset wraps from 0x7FF to 0x000 within the same packet page.
- R11: In a cycle where ptr_load is high, a data-port request is not acknowledged.
- R12: A byte read returns the addressed byte in dp_rdata[7:0] with the upper byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_load | input | 1 | Pointer load request, held until ptr_ack |
| ld_offset | input | 11 | Offset to load |
| ld_read | input | 1 | Direction to load: 1 read, 0 write |
| ld_rx | input | 1 | Area select to load: 1 receive queue head, 0 packet number register |
| ld_autoinc | input | 1 | Auto-increment enable to load |
| ptr_ack | output | 1 | Pointer load accepted at this edge |
| ptr_offset | output | 11 | Offset of the last host-accessed location |
| ptr_read | output | 1 | Current direction |
| ptr_rx | output | 1 | Current area select |
| ptr_autoinc | output | 1 | Current auto-increment enable |
| pnum_reg | input | 5 | Packet number register value |
| rxq_head | input | 5 | Packet number at the receive queue head |
| dp_req | input | 1 | Data-port access request, held until dp_ack |
| dp_word | input | 1 | Access size: 1 word, 0 byte |
| dp_wdata | input | 16 | Write data |
| dp_ack | output | 1 | Data-port access accepted at this edge |
| dp_rdata | output | 16 | Read data |
| data_ready | output | 1 | Prefetched data is valid |
| wr_pending | output | 1 | Write queue is not empty |
| mem_re | output | 1 | Buffer read strobe |
| mem_we | output | 1 | Buffer write strobe |
| mem_word | output | 1 | Buffer access size: 1 word, 0 byte |
| mem_addr | output | 16 | Buffer byte address |
| mem_wdata | output | 16 | Buffer write data |
| mem_rdata | input | 16 | Buffer read data, valid one cycle after mem_re |
| mem_wgnt | input | 1 | Memory takes the presented write |

## Verification
The collision that matters is between a pointer load and data-port traffic in the same cycle. One case is a load raised while a data request is also raised in read mode with data ready. The bench drives both in one cycle and expects dp_ack low and ptr_ack high. The other case is a load raised while queued writes are still draining. The bench stalls the memory grant until the queue is full, requests a load, then releases the grant. It expects the load to wait exactly as many cycles as there were queued entries, and checks that every queued write lands with its own address and data before the read-back.

// File: rtl/pktbuf_ptr_port.sv
`timescale 1ns/1ps
module pktbuf_ptr_port #(
  parameter int OFS_W    = 11,
  parameter int PN_W     = 5,
  parameter int DW       = 16,
  parameter int WF_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_load,
  input  logic [OFS_W-1:0] ld_offset,
  input  logic             ld_read,
  input  logic             ld_rx,
  input  logic             ld_autoinc,
  output logic             ptr_ack,
  output logic [OFS_W-1:0] ptr_offset,
  output logic             ptr_read,
  output logic             ptr_rx,
  output logic             ptr_autoinc,
  input  logic [PN_W-1:0]  pnum_reg,
  input  logic [PN_W-1:0]  rxq_head,
  input  logic             dp_req,
  input  logic             dp_word,
  input  logic [DW-1:0]    dp_wdata,
  output logic             dp_ack,
  output logic [DW-1:0]    dp_rdata,
  output logic             data_ready,
  output logic             wr_pending,
  output logic             mem_re,
  output logic             mem_we,
  output logic             mem_word,
  output logic [OFS_W+PN_W-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_wgnt
);
  localparam int AW = OFS_W + PN_W;
  localparam int QW = $clog2(WF_DEPTH);
  localparam int BW = DW / 2;

  logic [OFS_W-1:0] hofs, nofs;
  logic rd_mode, rx_mode, ai_mode;
  logic fetch_req, fetch_wait, rdy;
  logic [DW-1:0] dreg;

  logic [AW-1:0] q_addr [WF_DEPTH];
  logic          q_word [WF_DEPTH];
  logic [DW-1:0] q_data [WF_DEPTH];
  logic [QW-1:0] wp, rp;
  logic [QW:0]   cnt;

  wire [PN_W-1:0]  pn_sel   = rx_mode ? rxq_head : pnum_reg;
  wire             q_full   = (cnt == (QW+1)'(WF_DEPTH));
  wire [OFS_W-1:0] step     = dp_word ? OFS_W'(2) : OFS_W'(1);
  wire [OFS_W-1:0] nofs_adv = ai_mode ? nofs + step : nofs;
  wire             pop      = mem_we && mem_wgnt;

  assign wr_pending  = (cnt != '0);
  assign ptr_ack     = ptr_load && !wr_pending;
  assign dp_ack      = dp_req && !ptr_load && (rd_mode ? rdy : !q_full);
  wire   rd_acc      = dp_ack && rd_mode;
  wire   wr_acc      = dp_ack && !rd_mode;

  assign ptr_offset  = hofs;
  assign ptr_read    = rd_mode;
  assign ptr_rx      = rx_mode;
  assign ptr_autoinc = ai_mode;
  assign data_ready  = rdy;
  assign dp_rdata    = dp_word ? dreg : {{(DW-BW){1'b0}}, dreg[BW-1:0]};

  assign mem_re    = fetch_req;
  assign mem_we    = wr_pending;
  assign mem_word  = mem_we ? q_word[rp] : 1'b1;
  assign mem_addr  = mem_we ? q_addr[rp] : {pn_sel, nofs};
  assign mem_wdata = q_data[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hofs       <= '0;
      nofs       <= '0;
      rd_mode    <= 1'b0;
      rx_mode    <= 1'b0;
      ai_mode    <= 1'b0;
      fetch_req  <= 1'b0;
      fetch_wait <= 1'b0;
      rdy        <= 1'b0;
      dreg       <= '0;
    end else if (ptr_ack) begin
      hofs       <= ld_offset;
      nofs       <= ld_offset;
      rd_mode    <= ld_read;
      rx_mode    <= ld_rx;
      ai_mode    <= ld_autoinc;
      fetch_req  <= ld_read;
      fetch_wait <= 1'b0;
      rdy        <= 1'b0;
    end else begin
      if (dp_ack) begin
        hofs <= nofs;
        nofs <= nofs_adv;
      end
      if (rd_acc) begin
        rdy       <= 1'b0;
        fetch_req <= 1'b1;
      end else if (fetch_req) begin
        fetch_req  <= 1'b0;
        fetch_wait <= 1'b1;
      end
      if (fetch_wait) begin
        fetch_wait <= 1'b0;
        rdy        <= 1'b1;
        dreg       <= mem_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_acc) wp <= (wp == QW'(WF_DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)    rp <= (rp == QW'(WF_DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + {{QW{1'b0}}, wr_acc} - {{QW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) begin
      q_addr[wp] <= {pn_sel, nofs};
      q_word[wp] <= dp_word;
      q_data[wp] <= dp_wdata;
    end
  end
endmodule

// File: rtl/pktbuf_ptr_port_chk.sv
`timescale 1ns/1ps
module pktbuf_ptr_port_chk #(parameter int OFS_W = 11) (
  input logic             clk,
  input logic             rst_n,
  input logic             ptr_load,
  input logic             ptr_ack,
  input logic             ld_read,
  input logic [OFS_W-1:0] ld_offset,
  input logic [OFS_W-1:0] ptr_offset,
  input logic             dp_req,
  input logic             dp_ack,
  input logic             ptr_read,
  input logic             data_ready,
  input logic             wr_pending,
  input logic             mem_re,
  input logic             mem_we
);
  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load && wr_pending |-> !ptr_ack);
  // R11
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |-> !dp_ack);
  // R7
  read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_req && ptr_read && !data_ready |-> !dp_ack);
  // R2
  prefetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ack && ld_read |=> mem_re && !data_ready);
  // R6
  load_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ack |=> ptr_offset == $past(ld_offset));
  // R5
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  // R8
  wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_ack && !ptr_read |=> wr_pending);
endmodule

bind pktbuf_ptr_port pktbuf_ptr_port_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_ack(ptr_ack),
  .ld_read(ld_read), .ld_offset(ld_offset), .ptr_offset(ptr_offset),
  .dp_req(dp_req), .dp_ack(dp_ack), .ptr_read(ptr_read),
  .data_ready(data_ready), .wr_pending(wr_pending),
  .mem_re(mem_re), .mem_we(mem_we)
);

// File: tb/tb_pktbuf_ptr_port.sv
`timescale 1ns/1ps
module tb_pktbuf_ptr_port;
  logic clk = 0, rst_n = 0;
  logic ptr_load = 0, ld_read = 0, ld_rx = 0, ld_autoinc = 0;
  logic [10:0] ld_offset = '0;
  logic ptr_ack, ptr_read, ptr_rx, ptr_autoinc;
  logic [10:0] ptr_offset;
  logic [4:0] pnum_reg = 5'd3, rxq_head = 5'd9;
  logic dp_req = 0, dp_word = 0;
  logic [15:0] dp_wdata = '0;
  logic dp_ack, data_ready, wr_pending;
  logic [15:0] dp_rdata;
  logic mem_re, mem_we, mem_word;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic mem_wgnt = 1;

  always #2.5 clk = ~clk;

  pktbuf_ptr_port dut (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ld_offset(ld_offset),
    .ld_read(ld_read), .ld_rx(ld_rx), .ld_autoinc(ld_autoinc),
    .ptr_ack(ptr_ack), .ptr_offset(ptr_offset), .ptr_read(ptr_read),
    .ptr_rx(ptr_rx), .ptr_autoinc(ptr_autoinc), .pnum_reg(pnum_reg),
    .rxq_head(rxq_head), .dp_req(dp_req), .dp_word(dp_word),
    .dp_wdata(dp_wdata), .dp_ack(dp_ack), .dp_rdata(dp_rdata),
    .data_ready(data_ready), .wr_pending(wr_pending), .mem_re(mem_re),
    .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wgnt(mem_wgnt)
  );

  int errs = 0, checks = 0;
  logic [7:0] mem [int];
  logic [7:0] refm [int];
  logic [15:0] rexp [$];
  string rtag [$];
  int wa_q [$];
  logic [15:0] wd_q [$];
  bit ww_q [$];

  int cur_ofs = 0, last_acc = 0, last_waits = 0;
  bit cur_rx = 0, cur_ai = 0;

  function automatic logic [7:0] init_b(int a);
    return 8'(a * 13 + 7);
  endfunction
  function automatic int nb(int a);
    return (a & 'hF800) | ((a + 1) & 'h7FF);
  endfunction
  function automatic logic [7:0] memb(int a);
    return mem.exists(a) ? mem[a] : init_b(a);
  endfunction
  function automatic logic [7:0] refb(int a);
    return refm.exists(a) ? refm[a] : init_b(a);
  endfunction
  function automatic int cur_addr();
    return ((cur_rx ? int'(rxq_head) : int'(pnum_reg)) << 11) | cur_ofs;
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= {memb(nb(int'(mem_addr))), memb(int'(mem_addr))};
    if (mem_we && mem_wgnt) begin
      mem[int'(mem_addr)] = mem_wdata[7:0];
      if (mem_word) mem[nb(int'(mem_addr))] = mem_wdata[15:8];
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as the design produces results
  always @(negedge clk) begin
    #2;
    if (dp_req && dp_ack && ptr_read) begin
      logic [15:0] e;
      string t;
      e = rexp.pop_front();
      t = rtag.pop_front();
      chk(dp_rdata == e, t, dp_rdata, e);
    end
    if (mem_we && mem_wgnt) begin
      int a;
      logic [15:0] d;
      bit w;
      a = wa_q.pop_front();
      d = wd_q.pop_front();
      w = ww_q.pop_front();
      chk(int'(mem_addr) == a, "R5 write addr", mem_addr, a);
      chk(mem_word == w, "R5 write size", mem_word, w);
      chk((w ? mem_wdata : {8'h0, mem_wdata[7:0]}) == d, "R5 write data", mem_wdata, d);
    end
  end

  task automatic do_load(int ofs, bit rd, bit rx, bit ai);
    ld_offset = 11'(ofs); ld_read = rd; ld_rx = rx; ld_autoinc = ai;
    ptr_load = 1;
    last_waits = 0;
    #1;
    while (!ptr_ack) begin @(negedge clk); #1; last_waits++; end
    @(negedge clk);
    ptr_load = 0;
    cur_ofs = ofs; cur_rx = rx; cur_ai = ai;
  endtask

  task automatic do_read(bit w, string req);
    int a;
    a = cur_addr();
    rexp.push_back(w ? {refb(nb(a)), refb(a)} : {8'h0, refb(a)});
    rtag.push_back(req);
    dp_word = w; dp_req = 1;
    last_waits = 0;
    #1;
    while (!dp_ack) begin @(negedge clk); #1; last_waits++; end
    @(negedge clk);
    dp_req = 0;
    last_acc = cur_ofs;
    if (cur_ai) cur_ofs = (cur_ofs + (w ? 2 : 1)) & 'h7FF;
  endtask

  task automatic do_write(bit w, logic [15:0] d);
    int a;
    a = cur_addr();
    dp_word = w; dp_wdata = d; dp_req = 1;
    last_waits = 0;
    #1;
    while (!dp_ack) begin @(negedge clk); #1; last_waits++; end
    wa_q.push_back(a);
    wd_q.push_back(w ? d : {8'h0, d[7:0]});
    ww_q.push_back(w);
    refm[a] = d[7:0];
    if (w) refm[nb(a)] = d[15:8];
    @(negedge clk);
    dp_req = 0;
    last_acc = cur_ofs;
    if (cur_ai) cur_ofs = (cur_ofs + (w ? 2 : 1)) & 'h7FF;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #500000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ptr_offset == 0, "R1 offset", ptr_offset, 0);
    chk(data_ready == 0, "R1 data_ready", data_ready, 0);
    chk(wr_pending == 0, "R1 wr_pending", wr_pending, 0);
    chk(ptr_read == 0, "R1 direction", ptr_read, 0);

    // R2 prefetch timing after a read-mode load
    do_load('h010, 1, 0, 1);
    chk(data_ready == 0, "R2 ready early", data_ready, 0);
    chk(ptr_offset == 'h010, "R6 after load", ptr_offset, 'h010);
    @(negedge clk);
    chk(data_ready == 0, "R2 ready cycle1", data_ready, 0);
    @(negedge clk);
    chk(data_ready == 1, "R2 ready cycle2", data_ready, 1);

    // R2/R3 word reads with step 2, R7 stall length
    do_read(1, "R2 word read");
    do_read(1, "R3 word step");
    chk(last_waits == 2, "R7 stall cycles", last_waits, 2);
    do_read(1, "R3 word step");
    // R6 readback is last accessed, prefetch is ahead
    chk(ptr_offset == 'h014, "R6 readback", ptr_offset, 'h014);

    // R12 byte reads, R3 step 1
    do_read(0, "R12 byte read");
    do_read(0, "R3 byte step");
    chk(ptr_offset == 'h017, "R3 byte offset", ptr_offset, 'h017);

    // R11 load and data request in the same cycle
    repeat (3) @(negedge clk);
    chk(data_ready == 1, "R11 setup ready", data_ready, 1);
    ld_offset = 11'h040; ld_read = 1; ld_rx = 1; ld_autoinc = 0;
    ptr_load = 1; dp_req = 1; dp_word = 1;
    #1;
    chk(dp_ack == 0, "R11 data ack", dp_ack, 0);
    chk(ptr_ack == 1, "R11 load ack", ptr_ack, 1);
    @(negedge clk);
    ptr_load = 0; dp_req = 0;
    cur_ofs = 'h040; cur_rx = 1; cur_ai = 0;

    // R4 receive page select, R3 no auto-increment
    do_read(1, "R4 rx page");
    do_read(1, "R3 no advance");
    chk(ptr_offset == 'h040, "R3 no advance offset", ptr_offset, 'h040);
    chk(ptr_rx == 1, "R4 area bit", ptr_rx, 1);

    // R10 wrap inside the page
    do_load('h7FF, 1, 0, 1);
    do_read(0, "R10 last byte");
    do_read(0, "R10 wrapped byte");
    chk(ptr_offset == 0, "R10 wrap offset", ptr_offset, 0);

    // R5 write path then read back
    pnum_reg = 5'd2;
    do_load('h020, 0, 0, 1);
    do_write(1, 16'hBEEF);
    do_write(0, 16'h775A);
    do_write(1, 16'h1234);
    chk(ptr_offset == 'h023, "R6 write readback", ptr_offset, 'h023);
    do_load('h020, 1, 0, 1);
    do_read(1, "R5 word back");
    do_read(0, "R5 byte back");
    do_read(1, "R5 odd word back");

    // R8 queue full, R9 load held during drain
    mem_wgnt = 0;
    do_load('h100, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      do_write(1, 16'(16'hA000 + i * 16'h0111));
      chk(last_waits == 0, "R8 queue accepts", last_waits, 0);
    end
    chk(wr_pending == 1, "R8 pending flag", wr_pending, 1);
    dp_req = 1; dp_word = 1; dp_wdata = 16'hDEAD;
    #1;
    chk(dp_ack == 0, "R8 full stall", dp_ack, 0);
    dp_req = 0;
    ptr_load = 1; ld_offset = 11'h100; ld_read = 1;
    #1;
    chk(ptr_ack == 0, "R9 load held", ptr_ack, 0);
    ptr_load = 0;
    @(negedge clk);
    mem_wgnt = 1;
    do_load('h100, 1, 0, 1);
    chk(last_waits == 4, "R9 drain wait", last_waits, 4);
    chk(wr_pending == 0, "R8 drained", wr_pending, 0);
    for (int i = 0; i < 4; i++) do_read(1, "R8 queued data");

    repeat (4) @(negedge clk);
    chk(rexp.size() == 0, "R2 reads left", rexp.size(), 0);
    chk(wa_q.size() == 0, "R5 writes left", wa_q.size(), 0);
    finish_run();
  end
endmodule